// File: doc/BRIEF.md
# Clear-on-Compare 16-bit Timer

This block is a 16-bit up-counter for a timer peripheral. It advances only on cycles where an external prescaler raises a one-cycle tick. A mode field selects one of two behaviours. In free-running mode the count climbs to full scale and rolls over to zero. In clear-on-compare mode the count returns to zero after it reaches a TOP value. TOP comes either from compare register A or from the capture register.

Software reaches the block through a simple write port. One word address selects the counter, compare register A, the capture (TOP) register, the control word or the flag register. Three sticky flags report the following events:
- overflow;
- a compare-A match;
- a capture-register TOP match.

Each flag clears on an interrupt acknowledge or on a write-one-to-clear access. A compare output pin can toggle on each compare-A match, which gives a square wave at half the match rate. TOP writes are not buffered. A TOP written below the current count is missed until the counter has wrapped through 0xFFFF.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, compare register A, the capture register, all three flags and the compare pin are zero, and the mode is free-running. In free-running mode the count rises by one per tick from reset.
- R2: Without a tick and without a counter write, the count holds its value. This also applies while the count sits at TOP.
- R3: In free-running mode (control bits [3:0] = 0), each tick adds one, and 0xFFFF rolls over to 0x0000. A match with compare register A never clears the count in this mode.
- R4: The overflow flag (flag bit 0) is set on the same clock edge at which a tick takes the count from 0xFFFF to 0x0000.
- R5: With control bits [3:0] = 4, a count equal to compare register A stays there until the next tick. That tick clears the count to zero and sets the compare-A flag (flag bit 1).
- R6: With control bits [3:0] = 12, the capture register supplies TOP. The tick after the count equals it clears the count and sets the capture flag (flag bit 2), and only a tick can set that flag.
- R7: TOP registers act at once on write. If TOP is written below the current count, the count continues to 0xFFFF, wraps, and matches on the next pass.
- R8: When control bits [5:4] = 01, the compare pin toggles on every compare-A match. With bits [5:4] = 00 the pin does not change, and in all cases it changes only on a tick.
- R9: A counter write (address 0) wins over increment and clear in the same cycle. The compare match on the first tick after that write is suppressed.
- R10: Writing a 1 to a bit at address 4, or raising the matching intAck bit, clears that flag. Otherwise a flag stays set. A hardware set in the same cycle as a clear leaves the flag set.
- R11: A compare-A match also sets the compare-A flag in free-running mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler count enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Address: 0 count, 1 compare A, 2 capture/TOP, 3 control, 4 flags (write 1 to clear) |
| wrData | input | 16 | Write data; at address 3, bits [3:0] are the mode and bits [5:4] the pin mode |
| intAck | input | 3 | Interrupt acknowledge, one bit per flag |
| count | output | 16 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| cmpAFlag | output | 1 | Compare-A match flag |
| capFlag | output | 1 | Capture-register TOP flag |
| cmpOut | output | 1 | Compare output pin |

## Verification
The assertions check on every cycle that the count holds without a tick and that a tick either adds one or clears to zero. They also check that a counter write lands as written, that a tick at 0xFFFF raises overflow, that an unacknowledged overflow stays set, and that the pin and the capture flag move only on ticks. Only the directed scenarios can show the exact cycle of each clear against a chosen TOP. The same holds for which register supplies TOP in each mode, the missed-TOP run through a full wrap, the suppressed match after a counter write, and set-over-clear on a flag.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;
  localparam int CTRL_W = 6;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  localparam logic [3:0] MODE_FREE    = 4'd0;
  localparam logic [3:0] MODE_CTC_A   = 4'd4;
  localparam logic [3:0] MODE_CTC_CAP = 4'd12;
  localparam logic [1:0] PIN_TOGGLE   = 2'b01;

  localparam int FB_OVF  = 0;
  localparam int FB_CMPA = 1;
  localparam int FB_CAP  = 2;

  typedef struct packed {
    logic loadCnt;
    logic clrCnt;
    logic incCnt;
    logic wrCmpA;
    logic wrCap;
  } strobe_t;

  typedef struct packed {
    logic eqA;
    logic eqCap;
    logic atMax;
  } dpStat_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output dpStat_t          stat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpAQ;
  logic [CNT_W-1:0] capQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= wrData;
    end else if (strb.clrCnt) begin
      cntQ <= '0;
    end else if (strb.incCnt) begin
      cntQ <= cntQ + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpAQ <= '0;
      capQ  <= '0;
    end else begin
      if (strb.wrCmpA) cmpAQ <= wrData;
      if (strb.wrCap)  capQ  <= wrData;
    end
  end

  always_comb begin
    stat.eqA   = (cntQ == cmpAQ);
    stat.eqCap = (cntQ == capQ);
    stat.atMax = (cntQ == CNT_MAX);
  end

  assign count = cntQ;
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrCtl,
  input  logic [NFLAG-1:0]  intAck,
  input  dpStat_t           stat,
  output strobe_t           strb,
  output logic [NFLAG-1:0]  flags,
  output logic              cmpOut
);
  logic [3:0]       modeQ;
  logic [1:0]       pinModeQ;
  logic             blockNext;
  logic             pinQ;
  logic [NFLAG-1:0] flagQ;
  logic [NFLAG-1:0] setVec;
  logic [NFLAG-1:0] clrVec;

  logic cntWr, live, canMatch, ctcA, ctcCap, matchA, matchTop;

  always_comb begin
    cntWr    = wrEn && (wrAddr == A_CNT);
    live     = tick && !cntWr;
    canMatch = live && !blockNext;
    ctcA     = (modeQ == MODE_CTC_A);
    ctcCap   = (modeQ == MODE_CTC_CAP);
    matchA   = canMatch && stat.eqA;
    matchTop = canMatch && ((ctcA && stat.eqA) || (ctcCap && stat.eqCap));

    strb.loadCnt = cntWr;
    strb.clrCnt  = matchTop;
    strb.incCnt  = live && !matchTop;
    strb.wrCmpA  = wrEn && (wrAddr == A_CMPA);
    strb.wrCap   = wrEn && (wrAddr == A_CAP);

    setVec[FB_OVF]  = live && stat.atMax;
    setVec[FB_CMPA] = matchA;
    setVec[FB_CAP]  = matchTop && ctcCap;
    clrVec = intAck | ({NFLAG{wrEn && (wrAddr == A_FLAG)}} & wrCtl[NFLAG-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_FREE;
      pinModeQ <= 2'b00;
    end else if (wrEn && (wrAddr == A_CTRL)) begin
      modeQ    <= wrCtl[3:0];
      pinModeQ <= wrCtl[5:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockNext <= 1'b0;
    end else if (cntWr) begin
      blockNext <= 1'b1;
    end else if (tick) begin
      blockNext <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ <= 1'b0;
    end else if (matchA && (pinModeQ == PIN_TOGGLE)) begin
      pinQ <= ~pinQ;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
      end else begin
        flagQ[i] <= setVec[i] | (flagQ[i] & ~clrVec[i]);
      end
    end
  end

  assign flags  = flagQ;
  assign cmpOut = pinQ;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       intAck,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             cmpAFlag,
  output logic             capFlag,
  output logic             cmpOut
);
  strobe_t          strb;
  dpStat_t          stat;
  logic [NFLAG-1:0] flags;

  cmp_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .count  (count),
    .stat   (stat)
  );

  cmp_timer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrCtl  (wrData[CTRL_W-1:0]),
    .intAck (intAck),
    .stat   (stat),
    .strb   (strb),
    .flags  (flags),
    .cmpOut (cmpOut)
  );

  assign ovfFlag  = flags[FB_OVF];
  assign cmpAFlag = flags[FB_CMPA];
  assign capFlag  = flags[FB_CAP];
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [2:0]       intAck,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             cmpAFlag,
  input logic             capFlag,
  input logic             cmpOut
);
  logic cntWr, flagWr;
  assign cntWr  = wrEn && (wrAddr == A_CNT);
  assign flagWr = wrEn && (wrAddr == A_FLAG);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cntWr) |=> $stable(count)); // R2
  AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr) |=> ((count == $past(count) + CNT_W'(1)) || (count == '0))); // R3
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr && (count == '1)) |=> ovfFlag); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (count == $past(wrData))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !intAck[0] && !(flagWr && wrData[0])) |=> ovfFlag); // R10
  AST_PIN_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(cmpOut)); // R8
  AST_CAP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!capFlag && !tick) |=> !capFlag); // R6
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  intAck = '0;
  logic [15:0] count;
  logic        ovfFlag, cmpAFlag, capFlag, cmpOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] AD_CNT = 3'd0, AD_CMPA = 3'd1, AD_CAP = 3'd2, AD_CTRL = 3'd3, AD_FLAG = 3'd4;

  always #4 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .count(count), .ovfFlag(ovfFlag),
    .cmpAFlag(cmpAFlag), .capFlag(capFlag), .cmpOut(cmpOut)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input bit we, input logic [2:0] a, input logic [15:0] d, input bit t, input logic [2:0] ack);
    wrEn = we; wrAddr = a; wrData = d; tick = t; intAck = ack;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0; tick = 1'b0; intAck = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(1'b1, a, d, 1'b0, 3'b000);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, AD_CNT, 16'h0, 1'b1, 3'b000);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, AD_CNT, 16'h0, 1'b0, 3'b000);
  endtask

  task automatic t_reset;
    chk("R1", "count", count, 16'h0);
    chk("R1", "ovf", {15'b0, ovfFlag}, 16'h0);
    chk("R1", "cmpA flag", {15'b0, cmpAFlag}, 16'h0);
    chk("R1", "cap flag", {15'b0, capFlag}, 16'h0);
    chk("R1", "pin", {15'b0, cmpOut}, 16'h0);
    tk(3);
    chk("R1", "free-running count", count, 16'd3);
    chk("R11", "cmpA flag on match at 0", {15'b0, cmpAFlag}, 16'h1);
    chk("R8", "pin mode 00 no toggle", {15'b0, cmpOut}, 16'h0);
  endtask

  task automatic t_gate;
    idle(4);
    chk("R2", "hold without tick", count, 16'd3);
    tk(2);
    chk("R2", "two ticks", count, 16'd5);
  endtask

  task automatic t_wrap;
    wr(AD_CTRL, 16'h0000);
    wr(AD_CMPA, 16'h0010);
    wr(AD_CNT, 16'h000E);
    wr(AD_FLAG, 16'h0007);
    tk(3);
    chk("R3", "no clear at compare in free mode", count, 16'h0011);
    chk("R11", "cmpA flag free mode", {15'b0, cmpAFlag}, 16'h1);
    wr(AD_CNT, 16'hFFFE);
    wr(AD_FLAG, 16'h0007);
    tk(1);
    chk("R4", "count FFFF", count, 16'hFFFF);
    chk("R4", "ovf not yet", {15'b0, ovfFlag}, 16'h0);
    tk(1);
    chk("R3", "rollover", count, 16'h0000);
    chk("R4", "ovf set at wrap", {15'b0, ovfFlag}, 16'h1);
    wr(AD_FLAG, 16'h0001);
    chk("R10", "ovf W1C", {15'b0, ovfFlag}, 16'h0);
  endtask

  task automatic t_ctcA;
    wr(AD_CMPA, 16'd5);
    wr(AD_CTRL, 16'h0014);
    wr(AD_CNT, 16'd0);
    wr(AD_FLAG, 16'h0007);
    tk(5);
    chk("R5", "reach TOP", count, 16'd5);
    chk("R5", "flag not yet", {15'b0, cmpAFlag}, 16'h0);
    idle(2);
    chk("R2", "held at TOP", count, 16'd5);
    tk(1);
    chk("R5", "cleared after TOP", count, 16'd0);
    chk("R5", "cmpA flag", {15'b0, cmpAFlag}, 16'h1);
    chk("R8", "pin toggled high", {15'b0, cmpOut}, 16'h1);
    tk(6);
    chk("R5", "second period", count, 16'd0);
    chk("R8", "pin toggled low", {15'b0, cmpOut}, 16'h0);
  endtask

  task automatic t_ctcCap;
    wr(AD_CTRL, 16'h000C);
    wr(AD_CMPA, 16'd100);
    wr(AD_CAP, 16'd3);
    wr(AD_CNT, 16'd0);
    wr(AD_FLAG, 16'h0007);
    tk(3);
    chk("R6", "reach capture TOP", count, 16'd3);
    tk(1);
    chk("R6", "cleared at capture TOP", count, 16'd0);
    chk("R6", "cap flag", {15'b0, capFlag}, 16'h1);
    chk("R6", "no cmpA flag", {15'b0, cmpAFlag}, 16'h0);
  endtask

  task automatic t_nobuf;
    wr(AD_CTRL, 16'h0004);
    wr(AD_CMPA, 16'd50);
    wr(AD_CNT, 16'd40);
    wr(AD_FLAG, 16'h0007);
    tk(5);
    chk("R7", "before TOP change", count, 16'd45);
    wr(AD_CMPA, 16'd10);
    tk(65490);
    chk("R7", "ran to max", count, 16'hFFFF);
    chk("R7", "no match on the way", {15'b0, cmpAFlag}, 16'h0);
    tk(1);
    chk("R7", "wrapped", count, 16'h0);
    chk("R4", "ovf on missed-TOP wrap", {15'b0, ovfFlag}, 16'h1);
    tk(10);
    chk("R7", "at new TOP", count, 16'd10);
    tk(1);
    chk("R7", "cleared next pass", count, 16'd0);
    chk("R7", "cmpA flag next pass", {15'b0, cmpAFlag}, 16'h1);
  endtask

  task automatic t_prio;
    wr(AD_CTRL, 16'h0014);
    wr(AD_CMPA, 16'd7);
    wr(AD_CNT, 16'd3);
    wr(AD_FLAG, 16'h0007);
    tk(4);
    chk("R9", "at TOP", count, 16'd7);
    drive(1'b1, AD_CNT, 16'd7, 1'b1, 3'b000);
    chk("R9", "write beats clear", count, 16'd7);
    chk("R9", "no flag on write cycle", {15'b0, cmpAFlag}, 16'h0);
    tk(1);
    chk("R9", "match suppressed after write", count, 16'd8);
    chk("R9", "flag stays clear", {15'b0, cmpAFlag}, 16'h0);
    chk("R9", "pin unchanged", {15'b0, cmpOut}, 16'h0);
    drive(1'b1, AD_CNT, 16'd100, 1'b1, 3'b000);
    chk("R9", "write beats increment", count, 16'd100);
  endtask

  task automatic t_flags;
    wr(AD_CTRL, 16'h0004);
    wr(AD_CMPA, 16'd2);
    wr(AD_CNT, 16'd0);
    wr(AD_FLAG, 16'h0007);
    tk(2);
    drive(1'b1, AD_FLAG, 16'h0002, 1'b1, 3'b000);
    chk("R10", "set wins over clear", {15'b0, cmpAFlag}, 16'h1);
    chk("R5", "cleared with flag set", count, 16'd0);
    idle(2);
    chk("R10", "flag sticky", {15'b0, cmpAFlag}, 16'h1);
    drive(1'b0, AD_CNT, 16'h0, 1'b0, 3'b010);
    chk("R10", "ack clears cmpA", {15'b0, cmpAFlag}, 16'h0);
    wr(AD_CNT, 16'hFFFF);
    tk(1);
    chk("R4", "ovf set", {15'b0, ovfFlag}, 16'h1);
    wr(AD_FLAG, 16'h0002);
    chk("R10", "W1C other bit keeps ovf", {15'b0, ovfFlag}, 16'h1);
    drive(1'b0, AD_CNT, 16'h0, 1'b0, 3'b001);
    chk("R10", "ack clears ovf", {15'b0, ovfFlag}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_wrap();
    t_ctcA();
    t_ctcCap();
    t_nobuf();
    t_prio();
    t_flags();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule